// File: doc/BRIEF.md
# Interrupt Controller Command-Word Sequencer

This block sits behind the processor write port of a programmable interrupt controller. It decodes each write from the address line, the data byte and the current progress of setup, and sends the byte to exactly one control register. Setup is a chain of two to four bytes. The first byte says which of the optional third and fourth bytes will follow. After setup, three run-time control bytes can be written in any order.

The write strobe is asynchronous to the system clock. It is brought through a synchronizer, and each register loads on the rising edge of the strobe. One strobe pulse therefore moves the block by one step, however long the pulse is held low. The block does not resolve priority, run acknowledge cycles or drive the cascade bus. It only hands the mode and identity fields to the logic that does those jobs.

Top module: `pic_cmd_sequencer`

## Requirements
- R1: After reset, `init_done` is 0, `op_mask` is all ones, and every other stored register is 0.
- R2: A write with `a0`=0 and `din[4]`=1 starts setup in any state. It stores the byte in `init_w1`, clears `op_mask` to 0 and forces `init_done` to 0.
- R3: The first setup write after `init_w1` with `a0`=1 loads `init_w2`. While setup is in progress, a write with `a0`=0 and `din[4]`=0 changes nothing.
- R4: The next `a0`=1 write loads `init_w3` only when bit 1 of `init_w1` is 0 (cascade mode). When that bit is 1, this step is skipped.
- R5: `init_w4` is expected only when bit 0 of `init_w1` is 1. `init_done` rises after the last expected setup byte: the 2nd, 3rd or 4th.
- R6: A register loads within three clock cycles of the rising edge of `wr_n`. One strobe pulse loads at most one register, even when the strobe is held low for many cycles.
- R7: When `init_done` is 1, a write with `a0`=1 loads `op_mask`.
- R8: When `init_done` is 1, a write with `a0`=0, `din[4]`=0 loads `op_w2` if `din[3]`=0 and `op_w3` if `din[3]`=1. These writes may come in any order.
- R9: Before `init_done` has risen, writes meant for the run-time registers change neither `op_w2` nor `op_w3`. Before any setup, they also leave `op_mask` unchanged.
- R10: `cascade_mode` is the inverse of bit 1 of `init_w1`. `cascade_id` is the low `CAS_W` bits of `init_w3`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe, asynchronous |
| a0 | input | 1 | Register address line |
| din | input | DATA_W | Write data byte |
| init_w1 | output | DATA_W | First setup byte |
| init_w2 | output | DATA_W | Second setup byte |
| init_w3 | output | DATA_W | Third setup byte (cascade) |
| init_w4 | output | DATA_W | Fourth setup byte |
| op_mask | output | DATA_W | Interrupt mask |
| op_w2 | output | DATA_W | Second run-time control byte |
| op_w3 | output | DATA_W | Third run-time control byte |
| init_done | output | 1 | Setup sequence complete |
| cascade_mode | output | 1 | 1 when cascade mode is selected |
| cascade_id | output | CAS_W | Cascade identity field |

## Verification
The hardest situations to reach from the ports are a restart that lands partway through a setup sequence, and a stray `a0`=0 byte that arrives while the block waits for the third setup byte. The stimulus drives each setup path: single with and without the fourth byte, and cascade with and without the fourth byte. It then interrupts a sequence after its second byte and inserts a stray byte between the second and third bytes of a cascade setup. A strobe held low for ten cycles shows that a long pulse still makes only one step.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

   // Positions in the data byte that the decoder relies on
   localparam int BIT_START  = 4;   // a0=0 write with this bit set begins setup
   localparam int BIT_SEL    = 3;   // picks between the two a0=0 run-time registers
   localparam int BIT_SINGLE = 1;   // in first setup byte: 1 = single, 0 = cascade
   localparam int BIT_WANT4  = 0;   // in first setup byte: fourth byte follows

   // Register indices in the bank
   localparam int LD_W1   = 0;
   localparam int LD_W2   = 1;
   localparam int LD_W3   = 2;
   localparam int LD_W4   = 3;
   localparam int LD_MASK = 4;
   localparam int LD_OP2  = 5;
   localparam int LD_OP3  = 6;
   localparam int NUM_LD  = 7;

   typedef enum logic [2:0] {
      ST_UNINIT = 3'd0,
      ST_WANT2  = 3'd1,
      ST_WANT3  = 3'd2,
      ST_WANT4  = 3'd3,
      ST_READY  = 3'd4
   } seq_state_e;

endpackage

// File: rtl/pic_wr_capture.sv
module pic_wr_capture #(
   parameter int DATA_W = 8,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic              a0,
   input  logic [DATA_W-1:0] din,
   output logic              wr_ev,
   output logic              ev_a0,
   output logic [DATA_W-1:0] ev_data
);
   localparam int PW = DATA_W + 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pic_wr_capture: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] wr_pipe;
   logic [PW-1:0]     dat_pipe [STAGES];
   logic              wr_prev;
   logic [PW-1:0]     dat_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pipe[0]  <= 1'b1;
         dat_pipe[0] <= '0;
      end else begin
         wr_pipe[0]  <= wr_n;
         dat_pipe[0] <= {a0, din};
      end
   end

   generate
      for (genvar g = 1; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_pipe[g]  <= 1'b1;
               dat_pipe[g] <= '0;
            end else begin
               wr_pipe[g]  <= wr_pipe[g-1];
               dat_pipe[g] <= dat_pipe[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev  <= 1'b1;
         dat_prev <= '0;
      end else begin
         wr_prev  <= wr_pipe[STAGES-1];
         dat_prev <= dat_pipe[STAGES-1];
      end
   end

   // Rising edge of the strobe; the data is the last sample taken while it was low
   assign wr_ev   = !wr_prev && wr_pipe[STAGES-1];
   assign ev_a0   = dat_prev[DATA_W];
   assign ev_data = dat_prev[DATA_W-1:0];

   p_single_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ev |=> !wr_ev)
      else $error("strobe edge produced two events");

endmodule

// File: rtl/pic_seq_fsm.sv
module pic_seq_fsm
   import pic_cmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ev,
   input  logic              ev_a0,
   input  logic [DATA_W-1:0] ev_data,
   output logic [NUM_LD-1:0] ld,
   output logic              start,
   output logic              init_done
);
   seq_state_e state_q, state_d;
   logic       single_q, want4_q;
   logic       is_start;

   assign is_start = !ev_a0 && ev_data[BIT_START];
   assign start    = wr_ev && is_start;

   always_comb begin
      ld      = '0;
      state_d = state_q;
      if (wr_ev) begin
         if (is_start) begin
            ld[LD_W1] = 1'b1;
            state_d   = ST_WANT2;
         end else begin
            unique case (state_q)
               ST_WANT2: if (ev_a0) begin
                  ld[LD_W2] = 1'b1;
                  if (!single_q)    state_d = ST_WANT3;
                  else if (want4_q) state_d = ST_WANT4;
                  else              state_d = ST_READY;
               end
               ST_WANT3: if (ev_a0) begin
                  ld[LD_W3] = 1'b1;
                  state_d   = want4_q ? ST_WANT4 : ST_READY;
               end
               ST_WANT4: if (ev_a0) begin
                  ld[LD_W4] = 1'b1;
                  state_d   = ST_READY;
               end
               ST_READY: begin
                  if (ev_a0)                 ld[LD_MASK] = 1'b1;
                  else if (ev_data[BIT_SEL]) ld[LD_OP3]  = 1'b1;
                  else                       ld[LD_OP2]  = 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_UNINIT;
         single_q <= 1'b1;
         want4_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (start) begin
            single_q <= ev_data[BIT_SINGLE];
            want4_q  <= ev_data[BIT_WANT4];
         end
      end
   end

   assign init_done = (state_q == ST_READY);

   p_done_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> $past(wr_ev))
      else $error("setup completed without a write");

   p_restart_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !init_done)
      else $error("init_done stayed high after a restart");

endmodule

// File: rtl/pic_cmd_regs.sv
module pic_cmd_regs
   import pic_cmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_LD-1:0] ld,
   input  logic              start,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q [NUM_LD]
);
   generate
      for (genvar g = 0; g < NUM_LD; g++) begin : g_reg
         if (g == LD_MASK) begin : g_mask
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)     q[g] <= '1;
               else if (ld[g]) q[g] <= wdata;
               else if (start) q[g] <= '0;
            end
         end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)     q[g] <= '0;
               else if (ld[g]) q[g] <= wdata;
            end
         end
      end
   endgenerate

   p_one_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld))
      else $error("more than one register load in a cycle");

   p_mask_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (q[LD_MASK] == '0))
      else $error("mask not cleared by restart");

endmodule

// File: rtl/pic_cmd_sequencer.sv
module pic_cmd_sequencer
   import pic_cmd_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CAS_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic              a0,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] init_w1,
   output logic [DATA_W-1:0] init_w2,
   output logic [DATA_W-1:0] init_w3,
   output logic [DATA_W-1:0] init_w4,
   output logic [DATA_W-1:0] op_mask,
   output logic [DATA_W-1:0] op_w2,
   output logic [DATA_W-1:0] op_w3,
   output logic              init_done,
   output logic              cascade_mode,
   output logic [CAS_W-1:0]  cascade_id
);
   generate
      if (DATA_W < BIT_START + 1) begin : g_bad_width
         $error("pic_cmd_sequencer: DATA_W too small for decode bits");
      end
      if (CAS_W < 1 || CAS_W > DATA_W) begin : g_bad_cas
         $error("pic_cmd_sequencer: CAS_W out of range");
      end
   endgenerate

   logic              wr_ev, ev_a0, start;
   logic [DATA_W-1:0] ev_data;
   logic [NUM_LD-1:0] ld;
   logic [DATA_W-1:0] regs_q [NUM_LD];

   pic_wr_capture #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_cap (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .a0(a0), .din(din),
      .wr_ev(wr_ev), .ev_a0(ev_a0), .ev_data(ev_data)
   );

   pic_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_ev(wr_ev), .ev_a0(ev_a0), .ev_data(ev_data),
      .ld(ld), .start(start), .init_done(init_done)
   );

   pic_cmd_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .ld(ld), .start(start), .wdata(ev_data), .q(regs_q)
   );

   assign init_w1      = regs_q[LD_W1];
   assign init_w2      = regs_q[LD_W2];
   assign init_w3      = regs_q[LD_W3];
   assign init_w4      = regs_q[LD_W4];
   assign op_mask      = regs_q[LD_MASK];
   assign op_w2        = regs_q[LD_OP2];
   assign op_w3        = regs_q[LD_OP3];
   assign cascade_mode = !init_w1[BIT_SINGLE];
   assign cascade_id   = init_w3[CAS_W-1:0];

   p_ops_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |=> ($stable(op_w2) && $stable(op_w3)))
      else $error("run-time register changed before setup completed");

   p_mask_no_load_before_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_done && !start) |=> $stable(op_mask))
      else $error("mask changed before setup completed");

endmodule

// File: tb/pic_cmd_sequencer_bench.sv
module pic_cmd_sequencer_bench;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_n = 1'b1;
   logic          a0 = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] init_w1, init_w2, init_w3, init_w4, op_mask, op_w2, op_w3;
   logic          init_done, cascade_mode;
   logic [2:0]    cascade_id;

   always #2.5 clk = ~clk;

   pic_cmd_sequencer u_pic_cmd_sequencer (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .a0(a0), .din(din),
      .init_w1(init_w1), .init_w2(init_w2), .init_w3(init_w3), .init_w4(init_w4),
      .op_mask(op_mask), .op_w2(op_w2), .op_w3(op_w3), .init_done(init_done),
      .cascade_mode(cascade_mode), .cascade_id(cascade_id)
   );

   int    errors = 0;
   int    checks = 0;
   bit    busy = 1'b1;
   bit    finished = 1'b0;
   string tag = "R1";

   // Reference model: plain variables
   logic [DW-1:0] m_w [7];
   int            m_step;   // 0 none, 2..4 waiting for that byte, 5 ready
   bit            m_single, m_want4;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all(string req);
      chk(req, "init_w1", init_w1, m_w[0]);
      chk(req, "init_w2", init_w2, m_w[1]);
      chk(req, "init_w3", init_w3, m_w[2]);
      chk(req, "init_w4", init_w4, m_w[3]);
      chk(req, "op_mask", op_mask, m_w[4]);
      chk(req, "op_w2", op_w2, m_w[5]);
      chk(req, "op_w3", op_w3, m_w[6]);
      chk(req, "init_done", init_done, m_step == 5);
      chk("R10", "cascade_mode", cascade_mode, !m_w[0][1]);
      chk("R10", "cascade_id", cascade_id, m_w[2][2:0]);
   endtask

   function automatic void model_apply(bit wa, logic [DW-1:0] d);
      if (!wa && d[4]) begin
         m_w[0] = d; m_w[4] = '0; m_step = 2;
         m_single = d[1]; m_want4 = d[0];
      end else if (m_step == 5) begin
         if (wa)        m_w[4] = d;
         else if (d[3]) m_w[6] = d;
         else           m_w[5] = d;
      end else if (wa && m_step == 2) begin
         m_w[1] = d;
         m_step = !m_single ? 3 : (m_want4 ? 4 : 5);
      end else if (wa && m_step == 3) begin
         m_w[2] = d; m_step = m_want4 ? 4 : 5;
      end else if (wa && m_step == 4) begin
         m_w[3] = d; m_step = 5;
      end
   endfunction

   // One strobe pulse; the result is checked after the 3-cycle load latency
   task automatic wr(string req, bit wa, logic [DW-1:0] d, int low_cyc = 2);
      busy = 1'b1;
      tag  = req;
      @(negedge clk);
      a0 = wa; din = d; wr_n = 1'b0;
      repeat (low_cyc) @(negedge clk);
      if (low_cyc > 4) compare_all("R6");  // still low: nothing loaded yet
      wr_n = 1'b1;
      repeat (4) @(negedge clk);
      model_apply(wa, d);
      busy = 1'b0;
   endtask

   // Compare on every clock while idle
   always @(negedge clk) begin
      if (!busy && !finished) compare_all(tag);
   end

   initial begin
      #500000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 7; i++) m_w[i] = '0;
      m_w[4] = '1; m_step = 0; m_single = 1'b1; m_want4 = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset mask", op_mask, 8'hFF);
      chk("R1", "reset done", init_done, 0);
      busy = 1'b0; tag = "R1";
      repeat (3) @(negedge clk);

      // R9: run-time writes before any setup are ignored
      wr("R9", 1, 8'h55);
      wr("R9", 0, 8'h00);
      wr("R9", 0, 8'h0A);

      // Single mode with fourth byte: third step skipped (R4, R5)
      wr("R2", 0, 8'h13);
      wr("R3", 1, 8'h20);
      wr("R4", 1, 8'h03);
      chk("R5", "done after 4th", init_done, 1);

      // R7, R8: run-time bytes in mixed order
      wr("R7", 1, 8'hA5);
      wr("R8", 0, 8'h0B);
      wr("R8", 0, 8'h22);
      wr("R8", 0, 8'h08);
      wr("R7", 1, 8'h3C);

      // Cascade without fourth byte, stray a0=0 byte mid-sequence (R3, R10)
      wr("R2", 0, 8'h10);
      chk("R2", "mask cleared", op_mask, 0);
      chk("R2", "done dropped", init_done, 0);
      wr("R9", 1, 8'h40);
      wr("R3", 0, 8'h08);
      wr("R3", 0, 8'h00);
      wr("R4", 1, 8'h05);
      chk("R10", "cascade id", cascade_id, 5);
      chk("R5", "done after 3rd", init_done, 1);

      // Cascade with fourth byte
      wr("R2", 0, 8'h19);
      wr("R3", 1, 8'h48);
      wr("R4", 1, 8'h02);
      chk("R5", "not done before 4th", init_done, 0);
      wr("R5", 1, 8'h1D);

      // Restart partway through a sequence
      wr("R2", 0, 8'h11);
      wr("R3", 1, 8'h60);
      wr("R2", 0, 8'h12);
      wr("R3", 1, 8'h70);
      chk("R5", "done after 2nd", init_done, 1);

      // Long strobe gives one step (R6)
      wr("R6", 1, 8'h81, 10);
      wr("R6", 0, 8'h0E, 10);
      wr("R8", 0, 8'h04);

      repeat (5) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule